// File: doc/BRIEF.md
# Paged SRAM Window Mapper

This block sits between an 8-bit host memory bus and a byte-wide external SRAM. It takes each host byte offset inside an 8 KB card space and decides where the access goes. The access can go to a small on-card register window, to one of the real-time-clock areas, to one of two disk-controller register banks, or to the SRAM. For SRAM accesses it builds the physical address from a page register. The SRAM array, the clock device and the disk controller lie outside the block.

The page register changes only as a side effect of host writes. While paging is switched on, any write loads a new page number from the low address bits of that write. This includes writes that land in the register window. The lower 4 KB of the card space maps straight to the bottom of the SRAM unless paging of that half is forced. The upper 4 KB always goes through the page register. A write-protect control bit blocks SRAM writes.

The host side has no back-pressure. Each strobe is decoded in the cycle it is asserted, and the block never stalls the bus. Read and write strobes are never asserted together. Address, enables and selects are combinational from the host inputs and the current page. The page register updates on the clock edge that ends a write, so a write is decoded with the page number that was in force before it.

Top module: `sram_page_mapper`

## Requirements
- R1: An offset in 0x000..0x0FF goes to the register window only when ctl_sram_en equals dip_sram_en. Otherwise that offset, like every offset at 0x100 and above, goes to SRAM.
- R2: Inside the window, offset bits [6:5] pick one select strobe: 0 picks sel_rtc_ram, 1 picks sel_rtc_reg, 2 picks sel_ide1 and 3 picks sel_ide2. At most one select is high, and a select is high only during a read or write strobe.
- R3: While ctl_page_sw is high, a write strobe (SRAM or window) loads the page register with host_addr[6:1] ANDed with the page mask (default 0x3F). The new page takes effect from the next clock cycle.
- R4: The page register is 0 after reset. It keeps its value in any cycle that has no write strobe or has ctl_page_sw low.
- R5: An SRAM access uses the address {page, offset} (offset + 0x2000 × page) when ctl_force_page is high or offset bit 12 is set. Otherwise it uses the 13-bit offset with the upper address bits at zero.
- R6: sram_we stays low whenever ctl_wp is high.
- R7: sram_re follows a read strobe and sram_we follows a write strobe, and both are high only for accesses that go to SRAM.
- R8: For the clock RAM region, rtc_idx is {offset[7], offset[4:0]}. When bit 7 is set this gives the clock page register index (offset & 0x1F) | 0x20, and otherwise it is the offset itself.
- R9: For the clock register region, rtc_data_sel equals offset bit 4 (1 = register data, 0 = register select).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 13 | Host byte offset inside the card space |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| ctl_sram_en | input | 1 | Control bit compared with the switch to open the register window |
| dip_sram_en | input | 1 | Board switch level for the window comparison |
| ctl_page_sw | input | 1 | Allows writes to load the page register |
| ctl_force_page | input | 1 | Pages the lower 4 KB as well |
| ctl_wp | input | 1 | Write-protects the SRAM |
| sram_addr | output | 19 | Physical SRAM byte address |
| sram_re | output | 1 | SRAM read enable |
| sram_we | output | 1 | SRAM write enable |
| sel_rtc_ram | output | 1 | Clock RAM region select |
| sel_rtc_reg | output | 1 | Clock register region select |
| sel_ide1 | output | 1 | Disk register bank 1 select |
| sel_ide2 | output | 1 | Disk register bank 2 select |
| rtc_idx | output | 6 | Clock RAM or page register index |
| rtc_data_sel | output | 1 | Clock register data/select choice |

## Verification
The page register is the only state. A wrong value stays hidden until the next paged SRAM access, and then it shows up as wrong upper bits of sram_addr in that same cycle. For this reason the bench follows every page-loading write with paged reads at both 4 KB halves, with and without forcing. A decode fault shows up at once as a missing, doubled or misplaced strobe, so the bench walks the 0x0FF/0x100 and 0xFFF/0x1000 edges under both switch polarities.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int CARD_AW     = 13;   // 8 KB card space
  localparam int WIN_LIMIT   = 256;  // register window span
  localparam int NUM_REGIONS = 4;

  typedef enum logic [1:0] {
    RGN_RTC_RAM = 2'd0,
    RGN_RTC_REG = 2'd1,
    RGN_IDE_A   = 2'd2,
    RGN_IDE_B   = 2'd3
  } region_e;
endpackage

// File: rtl/spm_decode.sv
module spm_decode
  import spm_pkg::*;
(
  input  logic [CARD_AW-1:0]     addr_i,
  input  logic                   acc_i,
  input  logic                   sram_en_i,
  input  logic                   dip_i,
  output logic                   in_win_o,
  output logic [NUM_REGIONS-1:0] sel_o,
  output logic [5:0]             rtc_idx_o,
  output logic                   rtc_data_sel_o
);
  localparam int HI_W = CARD_AW - 8;

  region_e region;

  always_comb begin
    in_win_o = (addr_i[CARD_AW-1:8] == HI_W'(0)) && (sram_en_i == dip_i);
    region   = region_e'(addr_i[6:5]);
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sel
    assign sel_o[g] = acc_i && in_win_o && (region == region_e'(g));
  end

  // bit 7 chooses the clock page register (index 0x20 | low five bits)
  assign rtc_idx_o      = {addr_i[7], addr_i[4:0]};
  assign rtc_data_sel_o = addr_i[4];
endmodule

// File: rtl/spm_page_reg.sv
module spm_page_reg #(
  parameter int PAGE_MASK = 63,
  localparam int PAGE_W   = $clog2(PAGE_MASK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] bits_i,
  output logic [PAGE_W-1:0] page_o
);
  localparam logic [PAGE_W-1:0] MASK_V = PAGE_W'(PAGE_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      page_o <= '0;
    else if (load_i) page_o <= bits_i & MASK_V;
  end
endmodule

// File: rtl/spm_addr_gen.sv
module spm_addr_gen
  import spm_pkg::*;
#(
  parameter int PAGE_W = 6,
  localparam int AW    = CARD_AW + PAGE_W
) (
  input  logic [CARD_AW-1:0] addr_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               in_win_i,
  input  logic               force_i,
  input  logic               wp_i,
  output logic [AW-1:0]      sram_addr_o,
  output logic               sram_re_o,
  output logic               sram_we_o
);
  logic paged;

  always_comb begin
    paged       = force_i || addr_i[CARD_AW-1];
    sram_addr_o = paged ? {page_i, addr_i} : {PAGE_W'(0), addr_i};
    sram_re_o   = rd_i && !in_win_i;
    sram_we_o   = wr_i && !in_win_i && !wp_i;
  end
endmodule

// File: rtl/sram_page_mapper.sv
module sram_page_mapper
  import spm_pkg::*;
#(
  parameter int PAGE_MASK = 63,
  localparam int PAGE_W   = $clog2(PAGE_MASK + 1),
  localparam int AW       = CARD_AW + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CARD_AW-1:0] host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic               ctl_sram_en,
  input  logic               dip_sram_en,
  input  logic               ctl_page_sw,
  input  logic               ctl_force_page,
  input  logic               ctl_wp,
  output logic [AW-1:0]      sram_addr,
  output logic               sram_re,
  output logic               sram_we,
  output logic               sel_rtc_ram,
  output logic               sel_rtc_reg,
  output logic               sel_ide1,
  output logic               sel_ide2,
  output logic [5:0]         rtc_idx,
  output logic               rtc_data_sel
);
  logic                   in_win;
  logic [NUM_REGIONS-1:0] sel;
  logic [PAGE_W-1:0]      page_q;

  spm_decode u_dec (
    .addr_i         (host_addr),
    .acc_i          (host_rd || host_wr),
    .sram_en_i      (ctl_sram_en),
    .dip_i          (dip_sram_en),
    .in_win_o       (in_win),
    .sel_o          (sel),
    .rtc_idx_o      (rtc_idx),
    .rtc_data_sel_o (rtc_data_sel)
  );

  spm_page_reg #(.PAGE_MASK(PAGE_MASK)) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (host_wr && ctl_page_sw),
    .bits_i (host_addr[PAGE_W:1]),
    .page_o (page_q)
  );

  spm_addr_gen #(.PAGE_W(PAGE_W)) u_agen (
    .addr_i      (host_addr),
    .page_i      (page_q),
    .rd_i        (host_rd),
    .wr_i        (host_wr),
    .in_win_i    (in_win),
    .force_i     (ctl_force_page),
    .wp_i        (ctl_wp),
    .sram_addr_o (sram_addr),
    .sram_re_o   (sram_re),
    .sram_we_o   (sram_we)
  );

  assign sel_rtc_ram = sel[RGN_RTC_RAM];
  assign sel_rtc_reg = sel[RGN_RTC_REG];
  assign sel_ide1    = sel[RGN_IDE_A];
  assign sel_ide2    = sel[RGN_IDE_B];
endmodule

// File: rtl/spm_checker.sv
module spm_checker
  import spm_pkg::*;
#(
  parameter int PAGE_MASK = 63,
  localparam int PAGE_W   = $clog2(PAGE_MASK + 1),
  localparam int AW       = CARD_AW + PAGE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CARD_AW-1:0] host_addr,
  input logic               host_rd,
  input logic               host_wr,
  input logic               ctl_page_sw,
  input logic               ctl_force_page,
  input logic               ctl_wp,
  input logic [AW-1:0]      sram_addr,
  input logic               sram_re,
  input logic               sram_we,
  input logic               sel_rtc_ram,
  input logic               sel_rtc_reg,
  input logic               sel_ide1,
  input logic               sel_ide2,
  input logic [PAGE_W-1:0]  page_q
);
  localparam logic [PAGE_W-1:0] MASK_V = PAGE_W'(PAGE_MASK);

  logic any_sel;
  assign any_sel = sel_rtc_ram || sel_rtc_reg || sel_ide1 || sel_ide2;

  // R1
  window_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_sel |-> (!sram_re && !sram_we));

  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_rtc_ram, sel_rtc_reg, sel_ide1, sel_ide2}));

  // R2
  sel_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_sel |-> (host_rd || host_wr));

  // R3
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && ctl_page_sw) |=> (page_q == ($past(host_addr[PAGE_W:1]) & MASK_V)));

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && ctl_page_sw) |=> $stable(page_q));

  // R5
  low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sram_re || sram_we) && !ctl_force_page && !host_addr[CARD_AW-1])
      |-> (sram_addr[AW-1:CARD_AW] == PAGE_W'(0)));

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wp |-> !sram_we);

  // R7
  en_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_re |-> host_rd) and (sram_we |-> host_wr));
endmodule

bind sram_page_mapper spm_checker #(.PAGE_MASK(PAGE_MASK)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_addr      (host_addr),
  .host_rd        (host_rd),
  .host_wr        (host_wr),
  .ctl_page_sw    (ctl_page_sw),
  .ctl_force_page (ctl_force_page),
  .ctl_wp         (ctl_wp),
  .sram_addr      (sram_addr),
  .sram_re        (sram_re),
  .sram_we        (sram_we),
  .sel_rtc_ram    (sel_rtc_ram),
  .sel_rtc_reg    (sel_rtc_reg),
  .sel_ide1       (sel_ide1),
  .sel_ide2       (sel_ide2),
  .page_q         (page_q)
);

// File: tb/sram_page_mapper_test.sv
module sram_page_mapper_test;
  localparam int AW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] host_addr = '0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic ctl_sram_en = 1'b0, dip_sram_en = 1'b0;
  logic ctl_page_sw = 1'b0, ctl_force_page = 1'b0, ctl_wp = 1'b0;
  logic [AW-1:0] sram_addr;
  logic sram_re, sram_we;
  logic sel_rtc_ram, sel_rtc_reg, sel_ide1, sel_ide2;
  logic [5:0] rtc_idx;
  logic rtc_data_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [5:0] m_page = '0;

  always #4 clk = ~clk;

  sram_page_mapper uut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%0h)", tag, act, exp, host_addr);
    end
  endtask

  function automatic bit f_win(input logic [12:0] a, input bit sen, input bit dip);
    return (a < 13'h100) && (sen == dip);
  endfunction

  function automatic logic [AW-1:0] f_addr(input logic [12:0] a, input bit frc, input logic [5:0] pg);
    return (frc || a >= 13'h1000) ? {pg, a} : {6'd0, a};
  endfunction

  task automatic compare();
    bit win, acc;
    logic [3:0] esel;
    bit ere, ewe;
    win  = f_win(host_addr, ctl_sram_en, dip_sram_en);
    acc  = host_rd || host_wr;
    esel = '0;
    if (acc && win) esel[host_addr[6:5]] = 1'b1;
    ere = host_rd && !win;
    ewe = host_wr && !win && !ctl_wp;
    // R1 R2: window decode and region selects
    chk({sel_ide2, sel_ide1, sel_rtc_reg, sel_rtc_ram} == esel, "R1/R2 selects",
        {sel_ide2, sel_ide1, sel_rtc_reg, sel_rtc_ram}, esel);
    // R7: read enable
    chk(sram_re == ere, "R7 sram_re", sram_re, ere);
    // R6 R7: write enable with protection
    chk(sram_we == ewe, "R6/R7 sram_we", sram_we, ewe);
    // R5: physical address
    if (ere || ewe)
      chk(sram_addr == f_addr(host_addr, ctl_force_page, m_page), "R5 sram_addr",
          sram_addr, f_addr(host_addr, ctl_force_page, m_page));
    // R8: clock RAM index
    if (esel[0])
      chk(rtc_idx == {host_addr[7], host_addr[4:0]}, "R8 rtc_idx",
          rtc_idx, {host_addr[7], host_addr[4:0]});
    // R9: clock register choice
    if (esel[1])
      chk(rtc_data_sel == host_addr[4], "R9 rtc_data_sel", rtc_data_sel, host_addr[4]);
  endtask

  task automatic cyc(input logic [12:0] a, input bit rd, input bit wr, input bit sen,
                     input bit dip, input bit psw, input bit frc, input bit wp);
    @(negedge clk);
    host_addr = a; host_rd = rd; host_wr = wr;
    ctl_sram_en = sen; dip_sram_en = dip;
    ctl_page_sw = psw; ctl_force_page = frc; ctl_wp = wp;
    #1 compare();
    @(posedge clk);
    // R3 R4: reference page model
    if (rst_n && wr && psw) m_page = a[6:1] & 6'h3F;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R4: reset state, page 0 seen on a paged read
    #1;
    host_addr = 13'h1800; host_rd = 1'b1;
    #1 chk(sram_addr == 19'h01800, "R4 reset page", sram_addr, 19'h01800);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cyc(13'h1000, 1, 0, 0, 0, 0, 0, 0);            // R4 page still 0
    cyc(13'h00A4, 0, 1, 0, 0, 1, 0, 0);            // R3 window write loads page 0x12
    cyc(13'h1234, 1, 0, 0, 0, 0, 0, 0);            // R5 paged upper half
    cyc(13'h0FFF, 1, 0, 1, 0, 0, 0, 0);            // R5 lower half unpaged
    cyc(13'h0FFF, 1, 0, 1, 0, 0, 1, 0);            // R5 forced paging
    cyc(13'h1500, 0, 1, 0, 0, 0, 0, 1);            // R6 protected write
    cyc(13'h1FFE, 1, 0, 0, 0, 0, 0, 0);            // R4 page unchanged by no-load write
    cyc(13'h0050, 1, 0, 1, 0, 0, 0, 0);            // R1 switch mismatch goes to SRAM
    cyc(13'h00FF, 1, 0, 1, 1, 0, 0, 0);            // R1 top of window, R2 bank 2
    cyc(13'h0100, 1, 0, 1, 1, 0, 0, 0);            // R1 first SRAM offset
    cyc(13'h0094, 1, 0, 0, 0, 0, 0, 0);            // R8 clock page register index
    cyc(13'h0033, 0, 1, 1, 1, 0, 0, 0);            // R9 register data choice
    cyc(13'h1FFF, 0, 1, 0, 0, 1, 0, 0);            // R3 page 0x3F from SRAM write
    cyc(13'h1FFF, 1, 0, 0, 0, 0, 0, 0);            // R5 top physical byte
    cyc(13'h0000, 0, 0, 0, 0, 1, 0, 0);            // R4 no strobe, no load

    for (int i = 0; i < 3000; i++) begin
      logic [12:0] a;
      int k, op;
      k = $urandom_range(0, 3);
      a = (k == 0) ? 13'($urandom_range(0, 255)) :
          (k == 1) ? 13'($urandom_range(13'h0F00, 13'h10FF)) : 13'($urandom);
      op = $urandom_range(0, 2);
      cyc(a, op == 1, op == 2, 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), ($urandom_range(0, 3) == 0));
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule